// File: doc/BRIEF.md
# Step Attenuator Control with Fast Attack

This block drives a segmented step attenuator whose segments are each worth 0.5 dB. It takes a stored 8-bit control byte, a fast-attack pin and an enable pin. From them it produces a registered thermometer word, with one bit per segment. It also reports the total attenuation in half-dB units and a power-down flag. The low six bits of the byte hold a gain code. Each count of the gain code adds one segment, and codes past 40 saturate. The top two bits pick an overlay step, which is added only while the fast-attack pin is held high.

The fast-attack and enable pins are asynchronous to the system clock. Each passes through a flop synchronizer before use. The control byte is treated as already stable in the clock domain. Because the output is a thermometer code, a gain change only switches segments on or off at the boundary of the lit region. The word is registered, so it can change at most once per clock.

Top module: `step_atten_ctrl`

## Requirements
- R1: With enable high and fast attack low, a gain code n in the range 0..40 (byte bits [5:0]) gives atten_hdb = n.
- R2: Gain codes 41..63 give the same attenuation as code 40 (atten_hdb = 40 with fast attack low).
- R3: While fast attack is high, the overlay selected by byte bits [7:6] is added to the clamped code: 00 adds 4, 01 adds 8, 10 adds 16, 11 adds 32 half-dB units. The largest total is 72.
- R4: When fast attack returns low, atten_hdb returns to the clamped gain code.
- R5: therm_word is 72 bits wide. Bits [atten_hdb-1:0] are one and every higher bit is zero, so the word always has a single contiguous run of ones starting at bit 0.
- R6: While enable is low, therm_word is all ones, atten_hdb is 72 and pwr_down is 1, and the fast-attack pin has no effect. After enable returns high, the computed value comes back.
- R7: A change on fast_atk_in or enable_in reaches the outputs on the third rising clock edge after it. Two edges are spent in the synchronizer and one in the output register. A change of ctrl_byte reaches the outputs on the first rising edge after it.
- R8: Synchronous active-high reset puts the block in power-down: therm_word all ones, atten_hdb = 72, pwr_down = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_byte | input | 8 | Stored control byte: [7:6] overlay select, [5:0] gain code |
| fast_atk_in | input | 1 | Asynchronous fast-attack request, active high |
| enable_in | input | 1 | Asynchronous enable; low selects power-down |
| therm_word | output | 72 | Registered thermometer control word, one bit per 0.5 dB segment |
| atten_hdb | output | 7 | Current total attenuation in half-dB units |
| pwr_down | output | 1 | High while the block is powered down |

## Verification
On every cycle, the assertions check three properties of the output. The thermometer word keeps one contiguous run of ones from bit 0. Its population equals the reported attenuation. Power-down always lights every segment. They also tie the output register to the synchronized pins one cycle earlier: a clamped code with no overlay, a bounded overlay, and the power-down flag following enable. The exact code-to-attenuation values, the overlay table, the saturation above code 40 and the three-edge pin latency can only be shown by the bench's scenarios, which drive chosen bytes and pin sequences and sample at known edges.

// File: rtl/sac_pkg.sv
package sac_pkg;

    // Gain code field and its saturation point
    localparam int CODE_W      = 6;
    localparam int CODE_MAX    = 40;

    // Fast-attack overlay: smallest step and select width
    localparam int FA_SEL_W    = 2;
    localparam int FA_BASE_HDB = 4;
    localparam int FA_MAX_HDB  = FA_BASE_HDB << ((1 << FA_SEL_W) - 1);

    // Derived output sizes
    localparam int THERM_W     = CODE_MAX + FA_MAX_HDB;
    localparam int ATT_W       = $clog2(THERM_W + 1);

    typedef logic [ATT_W-1:0] att_t;

    typedef struct packed {
        logic [FA_SEL_W-1:0] fa_sel;
        logic [CODE_W-1:0]   gain_code;
    } ctrl_t;

    typedef struct packed {
        logic fast;
        logic en;
    } pins_t;

    // Saturate an out-of-range gain code at the last segment count
    function automatic att_t clamp_code(input logic [CODE_W-1:0] c);
        if (int'(c) > CODE_MAX)
            return att_t'(CODE_MAX);
        return att_t'(c);
    endfunction

    // Overlay size in half-dB units for a select value
    function automatic att_t fa_step(input logic [FA_SEL_W-1:0] s);
        return att_t'(FA_BASE_HDB) << s;
    endfunction

endpackage

// File: rtl/sac_sync.sv
module sac_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sac_decode.sv
module sac_decode
    import sac_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  fast,
    output att_t  code_clamped,
    output att_t  total
);

    att_t overlay;

    always_comb begin
        code_clamped = clamp_code(ctrl.gain_code);
        overlay      = fast ? fa_step(ctrl.fa_sel) : '0;
        total        = code_clamped + overlay;
    end

endmodule

// File: rtl/sac_therm.sv
module sac_therm
    import sac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pd,
    input  att_t               total,
    output logic [THERM_W-1:0] therm_q,
    output att_t               atten_q,
    output logic               pd_q
);

    logic [THERM_W-1:0] therm_next;
    logic [THERM_W-1:0] therm_inc;

    // One comparator per segment; power-down lights them all
    generate
        for (genvar i = 0; i < THERM_W; i++) begin : g_seg
            localparam att_t IDX = att_t'(i);
            assign therm_next[i] = pd | (total > IDX);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            therm_q <= '1;
            atten_q <= att_t'(THERM_W);
            pd_q    <= 1'b1;
        end else begin
            therm_q <= therm_next;
            atten_q <= pd ? att_t'(THERM_W) : total;
            pd_q    <= pd;
        end
    end

    assign therm_inc = therm_q + {{(THERM_W-1){1'b0}}, 1'b1};

    // R5: a single run of ones anchored at bit 0
    a_r5_therm_shape: assert property (@(posedge clk) disable iff (rst)
        (therm_inc & therm_q) == '0);

    // R5: segment count equals the reported attenuation
    a_r5_count_match: assert property (@(posedge clk) disable iff (rst)
        $countones(therm_q) == int'(atten_q));

    // R6: power-down lights every segment
    a_r6_pd_all_ones: assert property (@(posedge clk) disable iff (rst)
        pd_q |-> (&therm_q));

endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
    import sac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         ctrl_byte,
    input  logic               fast_atk_in,
    input  logic               enable_in,
    output logic [THERM_W-1:0] therm_word,
    output logic [ATT_W-1:0]   atten_hdb,
    output logic               pwr_down
);

    ctrl_t ctrl;
    pins_t pins_raw;
    pins_t pins_s;
    att_t  code_clamped;
    att_t  total;

    assign ctrl     = ctrl_t'(ctrl_byte);
    assign pins_raw = '{fast: fast_atk_in, en: enable_in};

    sac_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    sac_decode u_decode (
        .ctrl         (ctrl),
        .fast         (pins_s.fast),
        .code_clamped (code_clamped),
        .total        (total)
    );

    sac_therm u_therm (
        .clk     (clk),
        .rst     (rst),
        .pd      (~pins_s.en),
        .total   (total),
        .therm_q (therm_word),
        .atten_q (atten_hdb),
        .pd_q    (pwr_down)
    );

    // R1/R2: with no overlay the output follows the clamped code
    a_r1_plain_code: assert property (@(posedge clk) disable iff (rst)
        (pins_s.en && !pins_s.fast) |=> (atten_hdb == $past(code_clamped)));

    // R2: without the overlay, attenuation never passes the saturation point
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (pins_s.en && !pins_s.fast) |=> (int'(atten_hdb) <= CODE_MAX));

    // R3: the overlay adds at least its smallest step and stays in range
    a_r3_overlay_range: assert property (@(posedge clk) disable iff (rst)
        (pins_s.en && pins_s.fast) |=>
            (int'(atten_hdb) >= int'($past(code_clamped)) + FA_BASE_HDB &&
             int'(atten_hdb) <= THERM_W));

    // R6: the power-down flag follows the synchronized enable
    a_r6_pd_follows_en: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pwr_down == !$past(pins_s.en)));

endmodule

// File: tb/step_atten_ctrl_tb.sv
module step_atten_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 72;

    logic          clk = 1'b0;
    logic          rst;
    logic [7:0]    ctrl_byte;
    logic          fast_atk_in;
    logic          enable_in;
    logic [TW-1:0] therm_word;
    logic [6:0]    atten_hdb;
    logic          pwr_down;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    step_atten_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .ctrl_byte   (ctrl_byte),
        .fast_atk_in (fast_atk_in),
        .enable_in   (enable_in),
        .therm_word  (therm_word),
        .atten_hdb   (atten_hdb),
        .pwr_down    (pwr_down)
    );

    // Reference model built from the requirements
    function automatic int model(input logic [7:0] b, input bit fa, input bit en);
        int c;
        if (!en) return 72;
        c = int'(b[5:0]);
        if (c > 40) c = 40;
        if (fa) c = c + (4 << b[7:6]);
        return c;
    endfunction

    function automatic logic [TW-1:0] therm_of(input int n);
        logic [TW-1:0] w = '0;
        for (int i = 0; i < TW; i++) if (i < n) w[i] = 1'b1;
        return w;
    endfunction

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int exp_n, input bit exp_pd);
        logic [TW-1:0] exp_w = therm_of(exp_n);
        n_checks++;
        if (int'(atten_hdb) != exp_n || therm_word != exp_w || pwr_down != exp_pd) begin
            n_errors++;
            $display("FAIL %s: atten=%0d therm=%h pd=%0b, expected atten=%0d therm=%h pd=%0b",
                     req, atten_hdb, therm_word, pwr_down, exp_n, exp_w, exp_pd);
        end
    endtask

    task automatic apply(input logic [7:0] b, input bit fa, input bit en);
        ctrl_byte   = b;
        fast_atk_in = fa;
        enable_in   = en;
        edges(4);
    endtask

    // R8: reset state and the start-up path out of power-down
    task automatic t_reset();
        rst = 1'b1; ctrl_byte = 8'h05; fast_atk_in = 1'b0; enable_in = 1'b1;
        edges(3);
        chk("R8 reset", 72, 1'b1);
        rst = 1'b0;
        edges(2);
        chk("R8 still powered down before sync", 72, 1'b1);
        edges(1);
        chk("R8 leaves power-down", 5, 1'b0);
    endtask

    // R1: in-range gain codes
    task automatic t_codes();
        int codes[5] = '{0, 1, 17, 39, 40};
        foreach (codes[k]) begin
            apply(8'(codes[k]), 1'b0, 1'b1);
            chk($sformatf("R1 code %0d", codes[k]), model(8'(codes[k]), 0, 1), 1'b0);
        end
    endtask

    // R2: saturation above code 40
    task automatic t_clamp();
        int codes[3] = '{41, 50, 63};
        foreach (codes[k]) begin
            apply(8'(codes[k]), 1'b0, 1'b1);
            chk($sformatf("R2 clamp code %0d", codes[k]), 40, 1'b0);
        end
    endtask

    // R3 and R4: every overlay select, then release
    task automatic t_fast();
        for (int s = 0; s < 4; s++) begin
            logic [7:0] b = {2'(s), 6'd10};
            apply(b, 1'b1, 1'b1);
            chk($sformatf("R3 overlay sel %0d", s), 10 + (4 << s), 1'b0);
            apply(b, 1'b0, 1'b1);
            chk($sformatf("R4 release sel %0d", s), 10, 1'b0);
        end
        apply({2'b11, 6'd63}, 1'b1, 1'b1);
        chk("R3 maximum 72 with R5 full word", 72, 1'b0);
        apply({2'b11, 6'd63}, 1'b0, 1'b1);
        chk("R4 release to clamp", 40, 1'b0);
    endtask

    // R7: pin and byte latency
    task automatic t_latency();
        apply(8'h00, 1'b0, 1'b1);
        fast_atk_in = 1'b1;
        edges(2);
        chk("R7 fast pin after 2 edges", 0, 1'b0);
        edges(1);
        chk("R7 fast pin after 3 edges", 4, 1'b0);
        ctrl_byte = {2'b01, 6'd3};
        edges(1);
        chk("R7 byte after 1 edge", 11, 1'b0);
        fast_atk_in = 1'b0;
        edges(2);
        chk("R7 fast release after 2 edges", 11, 1'b0);
        edges(1);
        chk("R7 fast release after 3 edges", 3, 1'b0);
    endtask

    // R6: power-down, fast pin ignored, then recovery
    task automatic t_pd();
        apply(8'd20, 1'b0, 1'b1);
        chk("R6 before power-down", 20, 1'b0);
        enable_in = 1'b0;
        edges(2);
        chk("R6 enable drop after 2 edges", 20, 1'b0);
        edges(1);
        chk("R6 power-down", 72, 1'b1);
        fast_atk_in = 1'b1;
        ctrl_byte = 8'd2;
        edges(4);
        chk("R6 fast and byte ignored in power-down", 72, 1'b1);
        enable_in = 1'b1;
        edges(3);
        chk("R6 re-enable with overlay", 6, 1'b0);
        apply(8'd2, 1'b0, 1'b1);
        chk("R6 re-enable plain", 2, 1'b0);
    endtask

    initial begin
        rst = 1'b1; ctrl_byte = '0; fast_atk_in = 1'b0; enable_in = 1'b0;
        t_reset();
        t_codes();
        t_clamp();
        t_fast();
        t_latency();
        t_pd();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule